// File: doc/BRIEF.md
# 8-bit Timer with Synchronized Prescaler Reset

An 8-bit timer/counter clocked through a programmable prescaler, with two output-compare channels that can toggle, clear or set their pins when the counter meets a compare value. Counting runs either as a free 8-bit wrap or as clear-on-compare, where channel A's compare value sets the period. All configuration goes through a small synchronous register bus: address, write data, write strobe and combinational read data.

The prescaler has a reset bit that hardware normally drops one cycle after it is written. A companion hold bit keeps that reset asserted for as long as it is set. While the hold is on, the prescaler and counter are frozen, so software can load the counter, the compare values and the modes without the timer moving. Clearing the hold bit releases the reset, and counting restarts from a clean prescaler phase.

Register map (address: contents): 0 general control, with hold at bit 7 and prescaler reset at bit 0. 1 timer control, with channel A mode at 7:6, channel B mode at 5:4 and counting mode at 1:0 (00 wrap, 10 clear-on-compare, 01 and 11 behave as wrap). 2 clock select at 2:0. 3 counter. 4 compare A. 5 compare B. Unused bits and addresses read as zero.

Top module: `timer8_sync`

## Requirements
- R1: After reset, every register reads 0x00, both compare pins are 0, and both override and enable outputs are 0.
- R2: Writing 1 to the prescaler-reset bit (bit 0, address 0) with the hold bit (bit 7) at 0 makes the bit read 1 for one cycle. It reads 0 after the next clock edge.
- R3: While the hold bit is 1, a written prescaler-reset value of 1 stays set. The counter does not advance while that bit is 1.
- R4: Writing 0 to the hold bit releases the prescaler reset. With clock select 1, the counter reads k at the k-th clock edge after that write.
- R5: A channel mode field acts on a compare match: 01 toggles the pin, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R6: A channel's override output is 1 exactly when its mode field is nonzero. Its enable output is 1 only when the override is 1 and the channel's direction input is 1.
- R7: In wrap mode (counting mode 00) the counter goes from 255 to 0 on a tick.
- R8: In clear-on-compare mode (counting mode 10) the counter goes to 0 on the tick where it equals compare A.
- R9: A write to the counter suppresses compare actions on both channels for the next tick.
- R10: Clock select values 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Values 0, 6 and 7 stop the counter.
- R11: The prescaler phase restarts at zero on release. With divide-by-8 the first count after release lands at the 8th edge, and with divide-by-64 at the 64th.
- R12: A compare action updates the pin at the clock edge that ends the tick on which the counter equals the channel's compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data (combinational) |
| dir_a_i | input | 1 | Direction bit for channel A pin |
| dir_b_i | input | 1 | Direction bit for channel B pin |
| cmp_a_o | output | 1 | Channel A compare output level |
| cmp_b_o | output | 1 | Channel B compare output level |
| ovr_a_o | output | 1 | Channel A takes over its pin from port logic |
| ovr_b_o | output | 1 | Channel B takes over its pin from port logic |
| oe_a_o | output | 1 | Channel A pin driver enable |
| oe_b_o | output | 1 | Channel B pin driver enable |

## Verification
The counter is released from the hold state under divide-by-1, divide-by-8 and divide-by-64. Reading it one edge before and at each expected tick tells a correct prescaler phase restart apart from an off-by-one or stale phase. Compare channels are run with toggle, set, clear and disconnected modes on different compare values, which separates the mode decoding and the per-channel match from one another. A counter load that lands on the compare value shows whether the post-write suppression works, and runs in wrap and clear-on-compare modes distinguish the two period rules.

// File: rtl/timer8_pkg.sv
package timer8_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  localparam logic [1:0] WG_CTC = 2'b10;

  // mask of prescaler bits that must be all-ones for a tick; valid=0 stops
  function automatic logic [PRE_W:0] sel_mask(input logic [2:0] cs);
    case (cs)
      3'd1:    sel_mask = {1'b1, 10'h000};
      3'd2:    sel_mask = {1'b1, 10'h007};
      3'd3:    sel_mask = {1'b1, 10'h03f};
      3'd4:    sel_mask = {1'b1, 10'h0ff};
      3'd5:    sel_mask = {1'b1, 10'h3ff};
      default: sel_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/timer8_regs.sv
module timer8_regs
  import timer8_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] cnt_i,
  output logic          hold_o,
  output logic          psr_o,
  output logic [1:0]    mode_a_o,
  output logic [1:0]    mode_b_o,
  output logic [1:0]    wgm_o,
  output logic [2:0]    cs_o,
  output logic [DW-1:0] cmpa_o,
  output logic [DW-1:0] cmpb_o,
  output logic          cnt_wr_o
);
  localparam logic [AW-1:0] A_GCTL = AW'(0);
  localparam logic [AW-1:0] A_TCTL = AW'(1);
  localparam logic [AW-1:0] A_CS   = AW'(2);
  localparam logic [AW-1:0] A_CNT  = AW'(3);
  localparam logic [AW-1:0] A_CMPA = AW'(4);
  localparam logic [AW-1:0] A_CMPB = AW'(5);

  logic wr_gctl, wr_tctl, wr_cs, wr_cmpa, wr_cmpb;
  assign wr_gctl  = we_i && addr_i == A_GCTL;
  assign wr_tctl  = we_i && addr_i == A_TCTL;
  assign wr_cs    = we_i && addr_i == A_CS;
  assign cnt_wr_o = we_i && addr_i == A_CNT;
  assign wr_cmpa  = we_i && addr_i == A_CMPA;
  assign wr_cmpb  = we_i && addr_i == A_CMPB;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[6:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o   <= 1'b0;
      psr_o    <= 1'b0;
      mode_a_o <= '0;
      mode_b_o <= '0;
      wgm_o    <= '0;
      cs_o     <= '0;
      cmpa_o   <= '0;
      cmpb_o   <= '0;
    end else begin
      if (wr_gctl) begin
        hold_o <= wdata_i[7];
        psr_o  <= wdata_i[0];
      end else if (!hold_o) begin
        psr_o  <= 1'b0;   // self-clear unless held
      end
      if (wr_tctl) begin
        mode_a_o <= wdata_i[7:6];
        mode_b_o <= wdata_i[5:4];
        wgm_o    <= wdata_i[1:0];
      end
      if (wr_cs)   cs_o   <= wdata_i[2:0];
      if (wr_cmpa) cmpa_o <= wdata_i;
      if (wr_cmpb) cmpb_o <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_GCTL:  rdata_o = {hold_o, 6'b0, psr_o};
      A_TCTL:  rdata_o = {mode_a_o, mode_b_o, 2'b00, wgm_o};
      A_CS:    rdata_o = {5'b0, cs_o};
      A_CNT:   rdata_o = cnt_i;
      A_CMPA:  rdata_o = cmpa_o;
      A_CMPB:  rdata_o = cmpb_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/timer8_prescale.sv
module timer8_prescale
  import timer8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       psr_i,
  input  logic [2:0] cs_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   msk;

  assign msk    = sel_mask(cs_i);
  assign tick_o = msk[PRE_W] && !psr_i && ((pre_q & msk[PRE_W-1:0]) == msk[PRE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (psr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/timer8_core.sv
module timer8_core
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   wgm_i,
  input  logic [W-1:0] top_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         blk_o
);
  logic ctc;
  assign ctc = wgm_i == WG_CTC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      blk_o <= 1'b0;
    end else if (wr_i) begin
      cnt_o <= wdata_i;
      blk_o <= 1'b1;
    end else if (tick_i) begin
      blk_o <= 1'b0;
      if (ctc && cnt_o == top_i) cnt_o <= '0;
      else                       cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/timer8_ocu.sv
module timer8_ocu
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         blk_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [1:0]   mode_i,
  input  logic         dir_i,
  output logic         pin_o,
  output logic         ovr_o,
  output logic         oe_o
);
  logic act;
  assign act   = tick_i && !blk_i && cnt_i == cmp_i;
  assign ovr_o = |mode_i;
  assign oe_o  = ovr_o && dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else if (act) begin
      case (out_mode_e'(mode_i))
        OM_TOGGLE: pin_o <= ~pin_o;
        OM_CLEAR:  pin_o <= 1'b0;
        OM_SET:    pin_o <= 1'b1;
        default:   pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/timer8_sync.sv
module timer8_sync
  import timer8_pkg::*;
#(
  parameter int AW = 3,
  parameter int NCH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic            we_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic            dir_a_i,
  input  logic            dir_b_i,
  output logic            cmp_a_o,
  output logic            cmp_b_o,
  output logic            ovr_a_o,
  output logic            ovr_b_o,
  output logic            oe_a_o,
  output logic            oe_b_o
);
  logic             hold, psr, tick, cnt_wr, blk;
  logic [1:0]       mode_a, mode_b, wgm;
  logic [2:0]       cs;
  logic [CNT_W-1:0] cmpa, cmpb, cnt;

  timer8_regs #(.AW(AW), .DW(CNT_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .cnt_i(cnt), .hold_o(hold), .psr_o(psr), .mode_a_o(mode_a), .mode_b_o(mode_b),
    .wgm_o(wgm), .cs_o(cs), .cmpa_o(cmpa), .cmpb_o(cmpb), .cnt_wr_o(cnt_wr)
  );

  timer8_prescale u_pre (
    .clk_i, .rst_ni, .psr_i(psr), .cs_i(cs), .tick_o(tick)
  );

  timer8_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .wgm_i(wgm), .top_i(cmpa),
    .wr_i(cnt_wr), .wdata_i(wdata_i), .cnt_o(cnt), .blk_o(blk)
  );

  logic [NCH-1:0][CNT_W-1:0] ch_cmp;
  logic [NCH-1:0][1:0]       ch_mode;
  logic [NCH-1:0]            ch_dir, ch_pin, ch_ovr, ch_oe;
  assign ch_cmp  = {cmpb, cmpa};
  assign ch_mode = {mode_b, mode_a};
  assign ch_dir  = {dir_b_i, dir_a_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    timer8_ocu #(.W(CNT_W)) u_ocu (
      .clk_i, .rst_ni, .tick_i(tick), .blk_i(blk), .cnt_i(cnt),
      .cmp_i(ch_cmp[g]), .mode_i(ch_mode[g]), .dir_i(ch_dir[g]),
      .pin_o(ch_pin[g]), .ovr_o(ch_ovr[g]), .oe_o(ch_oe[g])
    );
  end

  assign cmp_a_o = ch_pin[0];
  assign cmp_b_o = ch_pin[1];
  assign ovr_a_o = ch_ovr[0];
  assign ovr_b_o = ch_ovr[1];
  assign oe_a_o  = ch_oe[0];
  assign oe_b_o  = ch_oe[1];
endmodule

// File: rtl/timer8_sync_chk.sv
module timer8_sync_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold,
  input logic       psr,
  input logic       we_i,
  input logic [2:0] addr_i,
  input logic       cnt_wr,
  input logic       tick,
  input logic       blk,
  input logic [1:0] wgm,
  input logic [7:0] cnt,
  input logic [7:0] cmpa,
  input logic [1:0] mode_a,
  input logic       cmp_a_o,
  input logic       cmp_b_o,
  input logic       ovr_a_o,
  input logic       oe_a_o
);
  logic gwr;
  assign gwr = we_i && addr_i == 3'd0;

  AST_PSR_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr && !hold && !gwr |=> !psr);  // R2
  AST_PSR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr && hold && !gwr |=> psr);  // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr && !cnt_wr |=> $stable(cnt));  // R3
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cnt_wr && wgm == 2'b00 && cnt == 8'hff |=> cnt == 8'h00);  // R7
  AST_CTC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cnt_wr && wgm == 2'b10 && cnt == cmpa |=> cnt == 8'h00);  // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk && !cnt_wr |=> $stable(cmp_a_o) && $stable(cmp_b_o));  // R9
  AST_OFF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_a == 2'b00 |=> $stable(cmp_a_o));  // R5
  AST_OE_NEEDS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_a_o |-> ovr_a_o);  // R6
endmodule

bind timer8_sync timer8_sync_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold(hold), .psr(psr), .we_i(we_i),
  .addr_i(addr_i), .cnt_wr(cnt_wr), .tick(tick), .blk(blk), .wgm(wgm),
  .cnt(cnt), .cmpa(cmpa), .mode_a(mode_a), .cmp_a_o(cmp_a_o),
  .cmp_b_o(cmp_b_o), .ovr_a_o(ovr_a_o), .oe_a_o(oe_a_o)
);

// File: tb/tb_timer8_sync.sv
`timescale 1ns/1ps
module tb_timer8_sync;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       we = 1'b0, dir_a = 1'b0, dir_b = 1'b0;
  logic       pa, pb, ova, ovb, oea, oeb;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  timer8_sync dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .dir_a_i(dir_a), .dir_b_i(dir_b), .cmp_a_o(pa), .cmp_b_o(pb),
    .ovr_a_o(ova), .ovr_b_o(ovb), .oe_a_o(oea), .oe_b_o(oeb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  // freeze, configure, load counter, then release (hold=0 written last)
  task automatic setup(input logic [7:0] tctl, input logic [2:0] cs,
                       input logic [7:0] ca, input logic [7:0] cb, input logic [7:0] c0);
    wr(3'd0, 8'h81);
    wr(3'd1, tctl); wr(3'd2, {5'b0, cs}); wr(3'd4, ca); wr(3'd5, cb); wr(3'd3, c0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 pins", {pa, pb, ova, ovb, oea, oeb}, 0);
  endtask

  task automatic t_psr_pulse;
    logic [7:0] d;
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R2 set", d, 8'h01);
    edges(1);
    rd(3'd0, d); chk("R2 cleared", d, 8'h00);
  endtask

  task automatic t_hold_release;
    logic [7:0] d;
    setup(8'h00, 3'd1, 8'd200, 8'd200, 8'd0);
    edges(10);
    rd(3'd0, d); chk("R3 psr held", d, 8'h81);
    rd(3'd3, d); chk("R3 frozen", d, 0);
    wr(3'd0, 8'h00);
    edges(5);
    rd(3'd3, d); chk("R4 count after release", d, 5);
  endtask

  task automatic t_div(input logic [2:0] cs, input int div);
    logic [7:0] d;
    setup(8'h00, cs, 8'd200, 8'd200, 8'd0);
    wr(3'd0, 8'h00);
    edges(div - 1);
    rd(3'd3, d); chk("R11 before first tick", d, 0);
    edges(1);
    rd(3'd3, d); chk("R11 first tick", d, 1);
    edges(div);
    rd(3'd3, d); chk("R10 second tick", d, 2);
  endtask

  task automatic t_stop;
    logic [7:0] d;
    setup(8'h00, 3'd6, 8'd200, 8'd200, 8'd7);
    wr(3'd0, 8'h00);
    edges(20);
    rd(3'd3, d); chk("R10 stopped", d, 7);
  endtask

  task automatic t_modes;
    logic [7:0] d;
    dir_a = 1'b1; dir_b = 1'b0;
    // A toggle @5, B set @3
    setup(8'h70, 3'd1, 8'd5, 8'd3, 8'd0);
    chk("R6 ovr a", ova, 1); chk("R6 oe a", oea, 1);
    chk("R6 ovr b", ovb, 1); chk("R6 oe b no dir", oeb, 0);
    wr(3'd0, 8'h00);
    edges(3); chk("R12 B before match", pb, 0);
    edges(1); chk("R5 B set", pb, 1);
    edges(1); chk("R12 A before match", pa, 0);
    edges(1); chk("R5 A toggle", pa, 1);
    edges(250);
    rd(3'd3, d); chk("R7 wrap", d, 0);
    chk("R7 A single toggle", pa, 1);
    // A off, B clear @3
    setup(8'h20, 3'd1, 8'd5, 8'd3, 8'd0);
    chk("R6 ovr a off", ova, 0); chk("R6 oe a off", oea, 0);
    wr(3'd0, 8'h00);
    edges(3); chk("R12 B clear pending", pb, 1);
    edges(1); chk("R5 B clear", pb, 0);
    edges(4); chk("R5 A off unchanged", pa, 1);
  endtask

  task automatic t_suppress;
    logic [7:0] d;
    // A toggle on cmpa=0, counter loaded to 0
    setup(8'h40, 3'd1, 8'd0, 8'd9, 8'd0);
    wr(3'd0, 8'h00);
    edges(5);
    chk("R9 no toggle after load", pa, 1);
    rd(3'd3, d); chk("R9 still counting", d, 5);
  endtask

  task automatic t_ctc;
    logic [7:0] d;
    setup(8'h42, 3'd1, 8'd4, 8'd9, 8'd0);
    wr(3'd0, 8'h00);
    edges(4);
    rd(3'd3, d); chk("R8 at top", d, 4);
    edges(1);
    rd(3'd3, d); chk("R8 cleared", d, 0);
    chk("R12 A toggled at top", pa, 0);
    edges(1);
    rd(3'd3, d); chk("R8 restart", d, 1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    edges(1);
    t_psr_pulse();
    t_hold_release();
    t_div(3'd2, 8);
    t_div(3'd3, 64);
    t_stop();
    t_modes();
    t_suppress();
    t_ctc();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule